// File: doc/BRIEF.md
# Staged Register Memory Port

This block lets a processing unit load words from, and store words into, an on-block storage array. Every access passes through two staging registers: an address staging register (MAR) and a data staging register (MDR). A load fills the MAR, pulses a read strobe, and then presents the fetched word in the MDR. A store fills the MDR first, then the MAR, and then pulses a write strobe. Each access takes three clock cycles, counting the cycle in which the request is accepted. The block handles one access at a time.

The request side is a valid/ready handshake. `req_ready` is high only while the port is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The client may hold `req_valid` high for as long as it likes, but the request fields are only sampled in the accepting cycle. The response side has no back-pressure. `done` pulses for one cycle, and on a load the word is in `mdr_o` during that cycle. The MDR keeps the word until the next access loads it again. The array holds `DEPTH` words, and its index is the low log2(`DEPTH`) bits of the MAR. The array is not cleared by reset.

Top module: `staged_mem_port`

## Requirements
- R1: While `rst` is high at a rising edge, the MAR, the MDR, `busy`, `done`, `rd_pulse` and `wr_pulse` become 0 and `req_ready` becomes 1.
- R2: A request is accepted in a cycle with `req_valid`=1 and `req_ready`=1. `req_write`=1 selects a store and `req_write`=0 selects a load. `req_ready` is low in the two cycles after acceptance.
- R3: After acceptance, `busy` is high for exactly two cycles. `done` is high only in the second of these cycles, which is the third cycle of the access, and lasts one cycle.
- R4: For a load, the MAR holds `req_addr` from the cycle after acceptance. `rd_pulse` is high in that cycle only. In the `done` cycle the MDR holds the addressed word.
- R5: For a store, the MDR holds `req_wdata` from the cycle after acceptance, while `wr_pulse` stays low. In the `done` cycle the MAR holds `req_addr` and `wr_pulse` is high. The word is written into the array at the end of that cycle. `rd_pulse` and `wr_pulse` are never high together.
- R6: A request presented while `busy` is high is ignored. It does not change the access in progress, and it writes no location.
- R7: A load returns the value most recently stored at the same array index. Addresses that differ only above the low log2(`DEPTH`) bits select the same location.
- R8: Reset leaves the array contents unchanged.
- R10: The MDR keeps its value from the end of one access until the next access loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Port idle, request can be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mar_o | output | ADDR_W | Address staging register |
| mdr_o | output | DATA_W | Data staging register, load result |
| rd_pulse | output | 1 | Read strobe to the array |
| wr_pulse | output | 1 | Write strobe to the array |

## Verification
The assertions assume that the request fields matter only in the accepting cycle, and that no location is read before it has been written, because the array has no reset value. The bench fills every location before it starts random traffic, and it keeps `req_valid` low outside its handshake. The one exception is a directed case that drives a conflicting store while the port is busy, to show that R6 holds. Random traffic draws full 16-bit addresses, so aliasing above the index bits is exercised all the time. A directed pair of accesses also checks aliasing on purpose.

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STEP2 = 2'd1,
    ST_STEP3 = 2'd2
  } step_e;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/smp_seq.sv
module smp_seq
  import smp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic busy,
  output logic done,
  output logic rd_strobe,
  output logic wr_strobe,
  output logic mar_from_req,
  output logic mar_from_pend,
  output logic mdr_from_req,
  output logic mdr_from_mem
);
  step_e state_q, state_d;
  op_e   op_q;
  logic  accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = !req_ready;
  assign done      = (state_q == ST_STEP3);

  // load: address first, then read strobe; store: data, then address, then write strobe
  assign rd_strobe     = (state_q == ST_STEP2) && (op_q == OP_LOAD);
  assign wr_strobe     = (state_q == ST_STEP3) && (op_q == OP_STORE);
  assign mar_from_req  = accept && !req_write;
  assign mdr_from_req  = accept && req_write;
  assign mar_from_pend = (state_q == ST_STEP2) && (op_q == OP_STORE);
  assign mdr_from_mem  = rd_strobe;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = ST_STEP2;
      ST_STEP2: state_d = ST_STEP3;
      ST_STEP3: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LOAD;
    end else begin
      state_q <= state_d;
      if (accept) op_q <= op_e'(req_write);
    end
  end

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> busy && !done && !req_ready);

  // R3
  accept_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |-> ##2 done);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_strobe, wr_strobe}));
endmodule

// File: rtl/smp_stage.sv
module smp_stage #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mar_from_req,
  input  logic              mar_from_pend,
  input  logic              mdr_from_req,
  input  logic              mdr_from_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_word,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mdr_q
);
  logic [ADDR_W-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      pend_q <= '0;
    end else begin
      if (mar_from_req)       mar_q <= req_addr;
      else if (mar_from_pend) mar_q <= pend_q;
      if (mdr_from_req) begin
        mdr_q  <= req_wdata;
        pend_q <= req_addr;
      end else if (mdr_from_mem) begin
        mdr_q <= mem_word;
      end
    end
  end

  // R4
  mar_load_chk: assert property (@(posedge clk) disable iff (rst)
    mar_from_req |=> mar_q == $past(req_addr));

  // R5
  mdr_load_chk: assert property (@(posedge clk) disable iff (rst)
    mdr_from_req |=> mdr_q == $past(req_wdata));

  // R10
  mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mdr_from_req && !mdr_from_mem |=> $stable(mdr_q));
endmodule

// File: rtl/smp_array.sv
module smp_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  // no reset: contents survive rst
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  // captured into the MDR at the next edge
  assign rd_word = mem[idx];
endmodule

// File: rtl/staged_mem_port.sv
module staged_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o,
  output logic              rd_pulse,
  output logic              wr_pulse
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              mar_from_req, mar_from_pend, mdr_from_req, mdr_from_mem;
  logic [DATA_W-1:0] arr_word;

  smp_seq u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_ready     (req_ready),
    .busy          (busy),
    .done          (done),
    .rd_strobe     (rd_pulse),
    .wr_strobe     (wr_pulse),
    .mar_from_req  (mar_from_req),
    .mar_from_pend (mar_from_pend),
    .mdr_from_req  (mdr_from_req),
    .mdr_from_mem  (mdr_from_mem)
  );

  smp_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stage (
    .clk           (clk),
    .rst           (rst),
    .mar_from_req  (mar_from_req),
    .mar_from_pend (mar_from_pend),
    .mdr_from_req  (mdr_from_req),
    .mdr_from_mem  (mdr_from_mem),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .mem_word      (arr_word),
    .mar_q         (mar_o),
    .mdr_q         (mdr_o)
  );

  smp_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .wr_en   (wr_pulse),
    .idx     (mar_o[IDX_W-1:0]),
    .wdata   (mdr_o),
    .rd_word (arr_word)
  );

  // R4
  rd_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> done && mdr_o == $past(arr_word));

  // R5
  wr_in_done_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> done && busy);

  // R6
  busy_mar_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> $stable(mar_o));
endmodule

// File: tb/tb_staged_mem_port.sv
module tb_staged_mem_port;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst, req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, busy, done, rd_pulse, wr_pulse;
  logic [AW-1:0] mar_o;
  logic [DW-1:0] mdr_o;

  staged_mem_port #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .mar_o(mar_o), .mdr_o(mdr_o),
    .rd_pulse(rd_pulse), .wr_pulse(wr_pulse)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [DEPTH];

  function automatic int slot(input logic [AW-1:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // called at a negedge with the port idle
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit intrude);
    logic [DW-1:0] exp_rd;
    exp_rd = model[slot(a)];
    check("R2 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    if (intrude) begin
      req_write = 1'b1; req_addr = a ^ 16'h0001; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    check("R3 busy cycle2", 32'(busy), 32'd1);
    check("R3 no done cycle2", 32'(done), 32'd0);
    check("R2 not ready cycle2", 32'(req_ready), 32'd0);
    if (!wr) begin
      check("R4 MAR loaded", 32'(mar_o), 32'(a));
      check("R4 read strobe", 32'(rd_pulse), 32'd1);
      check("R5 no write strobe on load", 32'(wr_pulse), 32'd0);
    end else begin
      check("R5 MDR loaded first", 32'(mdr_o), 32'(d));
      check("R5 no write strobe yet", 32'(wr_pulse), 32'd0);
      check("R5 no read strobe on store", 32'(rd_pulse), 32'd0);
    end
    @(negedge clk);
    check("R3 done cycle3", 32'(done), 32'd1);
    check("R3 busy cycle3", 32'(busy), 32'd1);
    if (!wr) begin
      check("R4/R7 read data", 32'(mdr_o), 32'(exp_rd));
      check("R4 strobe one cycle", 32'(rd_pulse), 32'd0);
      check("R4 MAR held", 32'(mar_o), 32'(a));
    end else begin
      check("R5 MAR loaded second", 32'(mar_o), 32'(a));
      check("R5 write strobe", 32'(wr_pulse), 32'd1);
      check("R5 MDR held", 32'(mdr_o), 32'(d));
      model[slot(a)] = d;
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R3 done one cycle", 32'(done), 32'd0);
    check("R3 busy cleared", 32'(busy), 32'd0);
    check("R10 MDR kept", 32'(mdr_o), wr ? 32'(d) : 32'(exp_rd));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=hung expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r1, r2;
    r1 = $urandom(32'd20240611);
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 MAR zero", 32'(mar_o), 32'd0);
    check("R1 MDR zero", 32'(mdr_o), 32'd0);
    check("R1 busy low", 32'(busy), 32'd0);
    check("R1 done low", 32'(done), 32'd0);
    check("R1 strobes low", 32'({rd_pulse, wr_pulse}), 32'd0);
    check("R1 ready high", 32'(req_ready), 32'd1);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < DEPTH; i++) begin
      r1 = $urandom;
      access(1'b1, AW'(i), r1[DW-1:0], 1'b0);
    end

    for (int n = 0; n < 400; n++) begin
      r1 = $urandom; r2 = $urandom;
      access(r2[31], r1[AW-1:0], r2[DW-1:0], 1'b0);
    end

    // R7 aliasing above the index bits
    access(1'b1, 16'h0045, 16'hBEEF, 1'b0);
    access(1'b0, 16'h0005, 16'h0000, 1'b0);
    check("R7 alias read", 32'(mdr_o), 32'h0000BEEF);
    access(1'b0, 16'hFFC5, 16'h0000, 1'b0);
    check("R7 alias high bits", 32'(mdr_o), 32'h0000BEEF);

    // R6 request while busy is ignored
    access(1'b1, 16'h0010, 16'h1234, 1'b1);
    access(1'b0, 16'h0011, 16'h0000, 1'b0);
    check("R6 intruding store ignored", 32'(mdr_o), 32'(model[17]));
    access(1'b0, 16'h0010, 16'h0000, 1'b0);
    check("R6 ongoing store intact", 32'(mdr_o), 32'h00001234);

    // R8 reset keeps array contents
    rst = 1'b1;
    @(negedge clk);
    check("R1 MDR cleared again", 32'(mdr_o), 32'd0);
    check("R1 MAR cleared again", 32'(mar_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    access(1'b0, 16'h0010, 16'h0000, 1'b0);
    check("R8 contents survive reset", 32'(mdr_o), 32'h00001234);
    access(1'b0, 16'h0005, 16'h0000, 1'b0);
    check("R8 second location survives", 32'(mdr_o), 32'h0000BEEF);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule